// File: doc/BRIEF.md
# Boost Converter Gate Pulse Controller

This block drives the gate of the power switch in a fixed-frequency boost converter. A free-running tick counter sets the switching period; 100 ticks of a 100 MHz clock give 1 µs, which is 1 MHz. Each period begins with the gate high. The gate falls once the tick count reaches the applied duty. The applied duty is the smallest of three values: the digital duty command (in place of the error-amplifier output), a fixed maximum of 90 ticks, and a soft-start limit. The soft-start limit climbs from zero to the maximum over about 1.5 ms.

Three comparator flags protect the power stage. An overcurrent flag seen during the on-time ends the pulse for the rest of that period. An overvoltage flag holds the gate low while it lasts. An undervoltage flag, like a low enable, holds the gate low and also sends the soft-start ramp back to zero, so that switching later restarts gently. All inputs are plain level signals sampled on the clock. No stream interface exists, so the block applies no back-pressure.

Top module: `bpg_gate_ctrl`

## Requirements
- R1: While switching is allowed, successive rising edges of `gate` are exactly TICKS_PER_PERIOD clock cycles apart. After reset, the first period starts TICKS_PER_PERIOD cycles after the release of reset.
- R2: The gate is high for exactly min(`duty_cmd`, DUTY_MAX, soft-start limit) cycles starting at each period start. A duty of zero gives no pulse at all.
- R3: Any command at or above DUTY_MAX (90 ticks of 100 by default) produces a pulse of exactly DUTY_MAX cycles. The gate is never high at a tick index of DUTY_MAX or above.
- R4: Enable goes high with no undervoltage present. After that, the soft-start limit starts at zero and rises by one every SS_TOTAL_TICKS/DUTY_MAX cycles until it equals DUTY_MAX. `soft_start` is high from the first cycle after enable is sampled high until the limit reaches DUTY_MAX. With step S it falls in the cycle after the (DUTY_MAX·S)-th sampled-high edge.
- R5: The applied duty is captured at each period start. A change of `duty_cmd` during a pulse leaves that pulse's width unchanged and takes effect in the next period.
- R6: `oc_flag` may be sampled high while the gate is high. The gate is then low from the next cycle to the end of the period, even if the flag drops again. The next period starts high again. If the flag is held high continuously, every period gives a pulse of one cycle.
- R7: While `ov_flag` is sampled high, the gate is low from the next cycle and `running` is low. The soft-start limit is kept, so pulses return at full commanded width once the flag clears.
- R8: While `en` is low or `uv_flag` is high, the gate is low from the next cycle, `running` and `soft_start` are low, and the soft-start limit returns to zero. When the condition clears, pulses restart narrow and follow the ramp.
- R9: During and straight after reset, `gate`, `running` and `soft_start` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable, active high |
| duty_cmd | input | DUTY_W | Commanded on-time in ticks |
| oc_flag | input | 1 | Overcurrent comparator output |
| ov_flag | input | 1 | Output overvoltage comparator output |
| uv_flag | input | 1 | Supply undervoltage comparator output |
| gate | output | 1 | Power switch gate drive, registered |
| running | output | 1 | Switching allowed (enabled, no OV, no UV) |
| soft_start | output | 1 | Running with the soft-start limit below the maximum |

## Verification
The period start and the overcurrent cut can fall in the same cycle. This happens when the overcurrent flag is still high as a new period begins. The bench holds `oc_flag` high across several period boundaries. The latch must clear and the gate must still open, so the bench expects a train of one-cycle pulses spaced one period apart. A second overlap is a command change during a live pulse. The bench changes `duty_cmd` in the first high cycle of a pulse and expects the old width on that pulse and the new width on the following one.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef struct packed {
    logic oc;
    logic ov;
    logic uv;
  } bpg_flags_t;

  // switching is permitted only when enabled and neither hard fault is present
  function automatic logic bpg_allow(input logic enable, input bpg_flags_t f);
    return enable && !f.ov && !f.uv;
  endfunction

  // soft-start ramp restarts from zero on disable or undervoltage
  function automatic logic bpg_ramp_clear(input logic enable, input bpg_flags_t f);
    return !enable || f.uv;
  endfunction

endpackage

// File: rtl/bpg_period_timer.sv
module bpg_period_timer #(
  parameter int TICKS = 100,
  parameter int CNT_W = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] tick,
  output logic [CNT_W-1:0] tick_next,
  output logic             last
);

  assign last      = (tick == CNT_W'(TICKS - 1));
  assign tick_next = last ? '0 : tick + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= '0;
    else        tick <= tick_next;
  end

  // R1: the counter wraps to zero after its final tick
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == CNT_W'(TICKS - 1)) |=> (tick == '0));

endmodule

// File: rtl/bpg_soft_ramp.sv
module bpg_soft_ramp #(
  parameter int DUTY_W     = 7,
  parameter int DUTY_MAX   = 90,
  parameter int STEP_TICKS = 1666,
  parameter int STEP_W     = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  output logic [DUTY_W-1:0] limit,
  output logic              at_max
);

  localparam logic [DUTY_W-1:0] ONE = {{(DUTY_W-1){1'b0}}, 1'b1};

  logic [STEP_W-1:0] step_cnt;

  assign at_max = (limit == DUTY_W'(DUTY_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      limit    <= '0;
      step_cnt <= '0;
    end else if (!at_max) begin
      if (step_cnt == STEP_W'(STEP_TICKS - 1)) begin
        step_cnt <= '0;
        limit    <= limit + ONE;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  // R4: the limit only moves upward one step at a time, or drops to zero
  p_ramp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != $past(limit)) |-> ((limit == $past(limit) + ONE) || (limit == '0)));

  // R8: a clear request empties the ramp on the following cycle
  p_ramp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (limit == '0));

endmodule

// File: rtl/bpg_gate_stage.sv
module bpg_gate_stage #(
  parameter int TICKS    = 100,
  parameter int DUTY_W   = 7,
  parameter int DUTY_MAX = 90,
  parameter int CNT_W    = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tick,
  input  logic [CNT_W-1:0]  tick_next,
  input  logic              last,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic [DUTY_W-1:0] ss_limit,
  input  logic              allow,
  input  logic              oc,
  output logic              gate
);

  logic [DUTY_W-1:0] duty_lat;
  logic [DUTY_W-1:0] clamp_cmd;
  logic [DUTY_W-1:0] applied;
  logic [DUTY_W-1:0] duty_use;
  logic              oc_lat;
  logic              oc_hit;
  logic              cut;

  always_comb begin
    clamp_cmd = (32'(duty_cmd) > DUTY_MAX) ? DUTY_W'(DUTY_MAX) : duty_cmd;
    applied   = (ss_limit < clamp_cmd) ? ss_limit : clamp_cmd;
    duty_use  = last ? applied : duty_lat;
    oc_hit    = oc && gate;
    cut       = !last && (oc_lat || oc_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_lat <= '0;
      oc_lat   <= 1'b0;
      gate     <= 1'b0;
    end else begin
      if (last) begin
        duty_lat <= applied;
        oc_lat   <= 1'b0;
      end else if (oc_hit) begin
        oc_lat   <= 1'b1;
      end
      gate <= allow && !cut && (32'(tick_next) < 32'(duty_use));
    end
  end

  // R6: overcurrent seen during the on-time ends the pulse next cycle
  p_oc_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oc && gate && !last) |=> !gate);

  // R3: the gate is never high at or beyond the maximum on-time tick
  p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (32'(tick) < DUTY_MAX));

  // R5: the captured duty holds steady within a period
  p_duty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(last) |-> $stable(duty_lat));

endmodule

// File: rtl/bpg_gate_ctrl.sv
module bpg_gate_ctrl
  import bpg_pkg::*;
#(
  parameter int TICKS_PER_PERIOD = 100,
  parameter int DUTY_W           = 7,
  parameter int DUTY_MAX         = 90,
  parameter int SS_TOTAL_TICKS   = 150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic              oc_flag,
  input  logic              ov_flag,
  input  logic              uv_flag,
  output logic              gate,
  output logic              running,
  output logic              soft_start
);

  localparam int CNT_W      = $clog2(TICKS_PER_PERIOD);
  localparam int STEP_RAW   = SS_TOTAL_TICKS / DUTY_MAX;
  localparam int STEP_TICKS = (STEP_RAW > 0) ? STEP_RAW : 1;

  bpg_flags_t        flags;
  logic              allow;
  logic              ramp_clear;
  logic [CNT_W-1:0]  tick;
  logic [CNT_W-1:0]  tick_next;
  logic              last;
  logic [DUTY_W-1:0] ss_limit;
  logic              ss_full;

  assign flags      = '{oc: oc_flag, ov: ov_flag, uv: uv_flag};
  assign allow      = bpg_allow(en, flags);
  assign ramp_clear = bpg_ramp_clear(en, flags);

  bpg_period_timer #(.TICKS(TICKS_PER_PERIOD), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tick_next (tick_next),
    .last      (last)
  );

  bpg_soft_ramp #(
    .DUTY_W     (DUTY_W),
    .DUTY_MAX   (DUTY_MAX),
    .STEP_TICKS (STEP_TICKS)
  ) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ramp_clear),
    .limit  (ss_limit),
    .at_max (ss_full)
  );

  bpg_gate_stage #(
    .TICKS    (TICKS_PER_PERIOD),
    .DUTY_W   (DUTY_W),
    .DUTY_MAX (DUTY_MAX),
    .CNT_W    (CNT_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tick_next (tick_next),
    .last      (last),
    .duty_cmd  (duty_cmd),
    .ss_limit  (ss_limit),
    .allow     (allow),
    .oc        (oc_flag),
    .gate      (gate)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) running <= 1'b0;
    else        running <= allow;
  end

  assign soft_start = running && !ss_full;

  // R7: overvoltage forces the gate low on the following cycle
  p_ov_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |=> (!gate && !running));

  // R8: disable or undervoltage stops switching and the ramp
  p_uv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || uv_flag) |=> (!gate && !soft_start && ss_limit == '0));

endmodule

// File: tb/bpg_gate_ctrl_test.sv
module bpg_gate_ctrl_test;

  localparam int P    = 20;
  localparam int DMAX = 18;
  localparam int STEP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [6:0] duty_cmd = '0;
  logic       oc_flag = 1'b0;
  logic       ov_flag = 1'b0;
  logic       uv_flag = 1'b0;
  logic       gate, running, soft_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bpg_gate_ctrl #(
    .TICKS_PER_PERIOD (P),
    .DUTY_W           (7),
    .DUTY_MAX         (DMAX),
    .SS_TOTAL_TICKS   (DMAX * STEP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .duty_cmd(duty_cmd),
    .oc_flag(oc_flag), .ov_flag(ov_flag), .uv_flag(uv_flag),
    .gate(gate), .running(running), .soft_start(soft_start)
  );

  typedef struct packed {
    logic [6:0] cmd;
    logic [6:0] width;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{7'd127, 7'd18}, '{7'd90, 7'd18}, '{7'd19, 7'd18}, '{7'd18, 7'd18},
    '{7'd17,  7'd17}, '{7'd9,  7'd9},  '{7'd2,  7'd2},  '{7'd1,  7'd1}
  };

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 change duty_cmd, 2 one-cycle oc pulse, 3 raise ov, 4 raise uv
  task automatic grab_pulse(input int kick_at, input int kind, input logic [6:0] val,
                            output int w);
    bit low_seen = 0;
    bit found = 0;
    bit oc_pulsed = 0;
    w = -1;
    for (int t = 0; t < 400 && !found; t++) begin
      @(negedge clk);
      if (!gate) low_seen = 1;
      else if (low_seen) found = 1;
    end
    if (!found) return;
    w = 1;
    for (int t = 0; t < 400; t++) begin
      if (w == kick_at) begin
        case (kind)
          1: duty_cmd = val;
          2: begin oc_flag = 1'b1; oc_pulsed = 1; end
          3: ov_flag = 1'b1;
          4: uv_flag = 1'b1;
          default: ;
        endcase
      end
      @(negedge clk);
      if (oc_pulsed) begin oc_flag = 1'b0; oc_pulsed = 0; end
      if (gate) w++;
      else break;
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate) hi++;
    end
  endtask

  task automatic rise_gap(output int gap);
    bit prev;
    int first = -1;
    gap = -1;
    @(negedge clk);
    prev = gate;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (gate && !prev) begin
        if (first < 0) first = t;
        else begin gap = t - first; break; end
      end
      prev = gate;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w, w2, hi, gap, prevw;
    bit mono;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset gate", gate == 1'b0, gate, 0);
    check("R9 reset status", !running && !soft_start, {running, soft_start}, 0);
    rst_n = 1'b1;

    // R8: disabled means no pulses
    duty_cmd = 7'd127;
    count_high(3 * P, hi);
    check("R8 disabled no pulses", hi == 0, hi, 0);
    check("R8 disabled running low", running == 1'b0, running, 0);

    // R4: soft-start window timing
    en = 1'b1;
    repeat (DMAX * STEP - 1) @(negedge clk);
    check("R4 soft_start high during ramp", soft_start == 1'b1, soft_start, 1);
    @(negedge clk);
    check("R4 soft_start low at ramp end", soft_start == 1'b0, soft_start, 0);

    // R1: period
    rise_gap(gap);
    check("R1 period", gap == P, gap, P);

    // R2 R3: vector table after the ramp has completed
    foreach (VECS[i]) begin
      duty_cmd = VECS[i].cmd;
      grab_pulse(0, 0, '0, w);
      grab_pulse(0, 0, '0, w);
      check("R2 R3 width", w == int'(VECS[i].width), w, int'(VECS[i].width));
    end

    // R2: zero duty gives no pulse
    duty_cmd = 7'd0;
    repeat (P + 1) @(negedge clk);
    count_high(3 * P, hi);
    check("R2 zero duty", hi == 0, hi, 0);

    // R5: change during a pulse applies next period
    duty_cmd = 7'd4;
    grab_pulse(0, 0, '0, w);
    grab_pulse(1, 1, 7'd15, w);
    check("R5 current pulse keeps old duty", w == 4, w, 4);
    grab_pulse(0, 0, '0, w);
    check("R5 next pulse uses new duty", w == 15, w, 15);

    // R6: overcurrent pulse cuts the on-time and latches until period end
    grab_pulse(4, 2, '0, w);
    check("R6 oc cut width", w == 4, w, 4);
    count_high(12, hi);
    check("R6 stays low rest of period", hi == 0, hi, 0);
    grab_pulse(0, 0, '0, w);
    check("R6 next period restored", w == 15, w, 15);

    // R6: oc held across period starts gives one-cycle pulses
    oc_flag = 1'b1;
    grab_pulse(0, 0, '0, w);
    grab_pulse(0, 0, '0, w2);
    check("R6 held oc one-cycle pulse", w == 1 && w2 == 1, w * 10 + w2, 11);
    oc_flag = 1'b0;

    // R7: overvoltage stops switching, ramp kept
    grab_pulse(0, 0, '0, w);
    grab_pulse(2, 3, '0, w);
    check("R7 ov cut width", w == 2, w, 2);
    check("R7 running low", running == 1'b0, running, 0);
    count_high(50, hi);
    check("R7 no pulses during ov", hi == 0, hi, 0);
    ov_flag = 1'b0;
    grab_pulse(0, 0, '0, w);
    check("R7 full width after ov", w == 15, w, 15);

    // R8: undervoltage stops switching and restarts the ramp
    grab_pulse(3, 4, '0, w);
    check("R8 uv cut width", w == 3, w, 3);
    count_high(50, hi);
    check("R8 no pulses during uv", hi == 0 && !running && !soft_start, hi, 0);
    uv_flag = 1'b0;
    @(negedge clk);
    check("R8 soft_start after uv", soft_start == 1'b1, soft_start, 1);
    grab_pulse(0, 0, '0, w);
    check("R8 first pulse narrow", w >= 1 && w < 15, w, 14);
    mono = 1;
    prevw = w;
    for (int k = 0; k < 5; k++) begin
      grab_pulse(0, 0, '0, w);
      if (w < prevw) mono = 0;
      prevw = w;
    end
    check("R4 ramp widths non-decreasing", mono, prevw, 15);
    check("R4 ramp reaches command", prevw == 15, prevw, 15);

    // R8: enable low stops switching
    en = 1'b0;
    @(negedge clk);
    check("R8 en low gate off", !gate && !running && !soft_start, gate, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule